// File: doc/BRIEF.md
# Interrupt Distributor Global Register Block

This block is the software-visible global register frame of an interrupt distributor. It decodes a 64 KiB address frame and answers accesses from a simple register bus. Each access carries an address, a byte length, write data and a read/write flag. The frame holds three words:

- a control word with a single writable enable for the non-secure interrupt group;
- a read-only type word computed from the number of shared interrupts;
- a constant identification word.

It also holds one 64-bit routing register per shared interrupt. Each routing register keeps a three-level affinity value for that interrupt.

The block drives a level output that reflects the group enable. It also drives a one-cycle kick pulse when the enable goes from cleared to set, so that downstream logic can rescan pending work. Every address the block does not map reads as zero and ignores writes. This covers the slice of routing registers that belongs to the private interrupt IDs and the routing slots beyond the implemented shared range.

Reads return their data one clock after the request, with a valid strobe. Writes take effect at the clock edge that samples them.

Top module: `dist_regs`

## Requirements
- R1: The control word is at offset 0x0000 and reads as 0x50 with bit 1 equal to the current group enable; that is, bits 4 and 6 always read 1. A control write takes bit 1 of the write data as the new enable and ignores all other bits.
- R2: `kick_o` is high for exactly one cycle, in the cycle after a control write that sets the enable while it was clear. A write that leaves the enable set, or that clears it, raises no kick.
- R3: The type word at offset 0x0004 reads ((NUM_SHARED + 32) / 32) − 1 in its low bits, ORed with (ID_BITS − 1) shifted left by 19. With the defaults this is 0x00480002.
- R4: Writes to the type word and to the identification word change neither; the identification word at offset 0x0008 always reads (PRODUCT_CODE << 24) | IMPL_CODE, which is 0x4B00043B with the defaults.
- R5: Routing registers sit at 0x6000 + 8·ID. A write to the lower word of the routing register (address bit 2 clear) of an implemented shared ID stores write-data bits 23:0 and discards the rest. The upper word (address bit 2 set) reads zero and ignores writes.
- R6: A routing read returns the stored 24-bit affinity, zero-extended, shifted down by 8·address[1:0] bits and masked to the request length in bytes (1, 2, 4, or any other value for 8).
- R7: The routing slots of IDs 0 to 31 read zero and ignore writes.
- R8: The routing slots of IDs at or above 32 + NUM_SHARED read zero and ignore writes.
- R9: The word at offset 0xFFE8 reads 0x3B. Every other unmapped offset, including the rest of 0xFFD0–0xFFFF, reads zero.
- R10: Synchronous reset clears the enable, the kick and every stored affinity.
- R11: Every read request produces `rsp_valid_o` one cycle later with its data, and a write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Access request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte offset within the 64 KiB frame |
| req_len_i | input | 4 | Access length in bytes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 64 | Read data |
| grp_enable_o | output | 1 | Group enable level |
| kick_o | output | 1 | One-cycle pulse on enable rising |

## Verification
A wrong enable state shows on the very next control read as bit 1. It also shows on `grp_enable_o` one cycle after the write, and as a missing or extra kick in that same cycle. A routing slot that is corrupted, or written through an aliasing decode, only shows when that slot is read back. For that reason the stimulus reads back the written slot, its neighbours, the upper word and the out-of-range slots after each write. A decode fault that lets a private or out-of-range write land in a real slot is exposed by the next read of the slot it aliases onto.

// File: rtl/dist_regs_pkg.sv
package dist_regs_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 64;
    localparam int LEN_W    = 4;
    localparam int INTID_W  = 10;
    localparam int PRIV_IDS = 32;
    localparam int AFF_W    = 24;

    localparam logic [2:0]  ROUTE_TOP   = 3'b011;        // 0x6000..0x7FFF
    localparam logic [13:0] PID2_WORD   = 14'h3FFA;      // 0xFFE8 >> 2
    localparam logic [31:0] CTRL_FIXED  = 32'h0000_0050; // bits 4 and 6
    localparam int          CTRL_EN_BIT = 1;
    localparam logic [31:0] PID2_VALUE  = 32'h0000_003B;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CTRL,
        RG_TYPE,
        RG_IDENT,
        RG_ROUTE,
        RG_PID2
    } region_e;

    typedef struct packed {
        region_e              region;
        logic [INTID_W-1:0]   slot;      // shared index (ID - 32)
        logic                 upper;     // upper word of a 64-bit register
        logic [1:0]           byte_off;  // byte offset within the word
    } decode_t;

    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        case (len)
            4'd1:    return 64'h0000_0000_0000_00FF;
            4'd2:    return 64'h0000_0000_0000_FFFF;
            4'd4:    return 64'h0000_0000_FFFF_FFFF;
            default: return '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_pick(
        input logic [DATA_W-1:0] value,
        input logic [1:0]        off,
        input logic [LEN_W-1:0]  len
    );
        return (value >> {off, 3'b000}) & len_mask(len);
    endfunction

    function automatic logic [31:0] type_word(input int num_shared, input int id_bits);
        logic [31:0] t;
        t = 32'((num_shared + PRIV_IDS) / 32 - 1);
        t = t | (32'(id_bits - 1) << 19);
        return t;
    endfunction

endpackage

// File: rtl/dist_decode.sv
module dist_decode
    import dist_regs_pkg::*;
#(
    parameter int NUM_SHARED = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    output decode_t           dec_o
);
    localparam int ID_LIMIT = PRIV_IDS + NUM_SHARED;

    logic [INTID_W-1:0] intid;
    assign intid = addr_i[12:3];

    always_comb begin
        dec_o          = '0;
        dec_o.region   = RG_NONE;
        dec_o.upper    = addr_i[2];
        dec_o.byte_off = addr_i[1:0];
        if (addr_i[15:4] == 12'h000) begin
            case (addr_i[3:2])
                2'd0:    dec_o.region = RG_CTRL;
                2'd1:    dec_o.region = RG_TYPE;
                2'd2:    dec_o.region = RG_IDENT;
                default: dec_o.region = RG_NONE;
            endcase
        end else if (addr_i[15:13] == ROUTE_TOP) begin
            if (int'(intid) >= PRIV_IDS && int'(intid) < ID_LIMIT) begin
                dec_o.region = RG_ROUTE;
                dec_o.slot   = intid - INTID_W'(PRIV_IDS);
            end
        end else if (addr_i[15:2] == PID2_WORD) begin
            dec_o.region = RG_PID2;
        end
    end

endmodule

// File: rtl/dist_ctrl.sv
module dist_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wr_en_i,
    input  logic wr_enable_i,
    output logic enable_o,
    output logic kick_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            enable_o <= 1'b0;
            kick_o   <= 1'b0;
        end else begin
            kick_o <= wr_en_i && wr_enable_i && !enable_o;
            if (wr_en_i) begin
                enable_o <= wr_enable_i;
            end
        end
    end
endmodule

// File: rtl/dist_route_store.sv
module dist_route_store
    import dist_regs_pkg::*;
#(
    parameter int NUM_SHARED = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [INTID_W-1:0] wr_slot_i,
    input  logic [AFF_W-1:0]   wr_aff_i,
    input  logic [INTID_W-1:0] rd_slot_i,
    output logic [AFF_W-1:0]   rd_aff_o
);
    logic [AFF_W-1:0] aff_q [NUM_SHARED];

    for (genvar g = 0; g < NUM_SHARED; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                aff_q[g] <= '0;
            end else if (wr_en_i && wr_slot_i == INTID_W'(g)) begin
                aff_q[g] <= wr_aff_i;
            end
        end
    end

    always_comb begin
        rd_aff_o = '0;
        for (int i = 0; i < NUM_SHARED; i++) begin
            if (rd_slot_i == INTID_W'(i)) begin
                rd_aff_o = aff_q[i];
            end
        end
    end
endmodule

// File: rtl/dist_regs.sv
module dist_regs
    import dist_regs_pkg::*;
#(
    parameter int          NUM_SHARED   = 64,
    parameter int          ID_BITS      = 10,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [15:0]       req_addr_i,
    input  logic [3:0]        req_len_i,
    input  logic [63:0]       req_wdata_i,
    output logic              rsp_valid_o,
    output logic [63:0]       rsp_rdata_o,
    output logic              grp_enable_o,
    output logic              kick_o
);
    localparam logic [31:0] TYPE_VALUE  = type_word(NUM_SHARED, ID_BITS);
    localparam logic [31:0] IDENT_VALUE = {PRODUCT_CODE, 12'h000, IMPL_CODE};

    decode_t          dec;
    logic             wr_req;
    logic             rd_req;
    logic             ctrl_wr;
    logic             route_wr;
    logic [AFF_W-1:0] route_aff;
    logic [63:0]      rdata_next;

    assign wr_req   = req_valid_i && req_write_i;
    assign rd_req   = req_valid_i && !req_write_i;
    assign ctrl_wr  = wr_req && dec.region == RG_CTRL;
    assign route_wr = wr_req && dec.region == RG_ROUTE && !dec.upper;

    dist_decode #(.NUM_SHARED(NUM_SHARED)) u_decode (
        .addr_i (req_addr_i),
        .dec_o  (dec)
    );

    dist_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (ctrl_wr),
        .wr_enable_i (req_wdata_i[CTRL_EN_BIT]),
        .enable_o    (grp_enable_o),
        .kick_o      (kick_o)
    );

    dist_route_store #(.NUM_SHARED(NUM_SHARED)) u_route (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (route_wr),
        .wr_slot_i (dec.slot),
        .wr_aff_i  (req_wdata_i[AFF_W-1:0]),
        .rd_slot_i (dec.slot),
        .rd_aff_o  (route_aff)
    );

    always_comb begin
        rdata_next = '0;
        case (dec.region)
            RG_CTRL:  rdata_next = {32'h0, CTRL_FIXED | (32'(grp_enable_o) << CTRL_EN_BIT)};
            RG_TYPE:  rdata_next = {32'h0, TYPE_VALUE};
            RG_IDENT: rdata_next = {32'h0, IDENT_VALUE};
            RG_ROUTE: begin
                if (!dec.upper) begin
                    rdata_next = lane_pick({{(DATA_W-AFF_W){1'b0}}, route_aff},
                                           dec.byte_off, req_len_i);
                end
            end
            RG_PID2:  rdata_next = {32'h0, PID2_VALUE};
            default:  rdata_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            rsp_valid_o <= rd_req;
            if (rd_req) begin
                rsp_rdata_o <= rdata_next;
            end
        end
    end
endmodule

// File: rtl/dist_regs_chk.sv
module dist_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic        req_write_i,
    input logic [15:0] req_addr_i,
    input logic        rsp_valid_o,
    input logic        grp_enable_o,
    input logic        kick_o
);
    // R2: a kick only accompanies a fresh rising of the enable
    a_r2_kick_on_rise: assert property (@(posedge clk) disable iff (rst)
        kick_o |-> (grp_enable_o && !$past(grp_enable_o)));

    // R2: the kick never lasts two cycles
    a_r2_kick_single: assert property (@(posedge clk) disable iff (rst)
        kick_o |=> !kick_o);

    // R1: the enable only moves after a control-word write
    a_r1_enable_held: assert property (@(posedge clk) disable iff (rst)
        !(req_valid_i && req_write_i && req_addr_i == 16'h0000) |=> $stable(grp_enable_o));

    // R11: a response follows exactly the read requests
    a_r11_rsp_after_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && !req_write_i) |=> rsp_valid_o);

    a_r11_no_rsp_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(req_valid_i && !req_write_i) |=> !rsp_valid_o);
endmodule

bind dist_regs dist_regs_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .rsp_valid_o  (rsp_valid_o),
    .grp_enable_o (grp_enable_o),
    .kick_o       (kick_o)
);

// File: tb/sim_dist_regs.sv
module sim_dist_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_len = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        grp_enable;
    logic        kick;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;   // 50 MHz

    dist_regs u0 (
        .clk          (clk),
        .rst          (rst),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .req_len_i    (req_len),
        .req_wdata_i  (req_wdata),
        .rsp_valid_o  (rsp_valid),
        .rsp_rdata_o  (rsp_rdata),
        .grp_enable_o (grp_enable),
        .kick_o       (kick)
    );

    function automatic logic [15:0] route_addr(input int id);
        return 16'h6000 + 16'(id * 8);
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 64'd1, 64'd0);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [3:0] l, input logic [63:0] d,
                      input logic exp_kick, input string tag);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_len = l; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check({tag, " kick"}, 64'(kick), 64'(exp_kick));
    endtask

    task automatic rd(input logic [15:0] a, input logic [3:0] l, input logic [63:0] e,
                      input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_len = l; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R10 / R1: reset state
        check("R10 enable after reset", 64'(grp_enable), 64'd0);
        check("R10 kick after reset", 64'(kick), 64'd0);
        rd(16'h0000, 4'd4, 64'h50, "R1 ctrl reset read");

        // R2: enable rising gives one kick
        wr(16'h0000, 4'd4, 64'h2, 1'b1, "R2 enable set");
        check("R1 enable level", 64'(grp_enable), 64'd1);
        @(negedge clk);
        check("R2 kick one cycle", 64'(kick), 64'd0);
        rd(16'h0000, 4'd4, 64'h52, "R1 ctrl enabled read");
        wr(16'h0000, 4'd4, 64'h2, 1'b0, "R2 re-enable no kick");
        wr(16'h0000, 4'd4, 64'h0, 1'b0, "R2 disable no kick");
        check("R1 enable cleared", 64'(grp_enable), 64'd0);
        wr(16'h0000, 4'd4, 64'hFFFF_FFFD, 1'b0, "R1 other bits ignored");
        rd(16'h0000, 4'd4, 64'h50, "R1 ctrl ignores other bits");

        // R3 / R4
        rd(16'h0004, 4'd4, 64'h0048_0002, "R3 type word");
        wr(16'h0004, 4'd4, 64'hFFFF_FFFF, 1'b0, "R4 type write");
        rd(16'h0004, 4'd4, 64'h0048_0002, "R4 type unchanged");
        wr(16'h0008, 4'd4, 64'h0, 1'b0, "R4 ident write");
        rd(16'h0008, 4'd4, 64'h4B00_043B, "R4 ident value");

        // R5 / R6 routing
        wr(route_addr(40), 4'd8, 64'h1234_5678_9ABC_DEF0, 1'b0, "R5 route write");
        rd(route_addr(40), 4'd8, 64'h00BC_DEF0, "R5 route keeps 24 bits");
        rd(route_addr(40) + 16'd1, 4'd1, 64'hDE, "R6 byte 1");
        rd(route_addr(40) + 16'd2, 4'd2, 64'h00BC, "R6 halfword at 2");
        rd(route_addr(40), 4'd4, 64'h00BC_DEF0, "R6 word read");
        rd(route_addr(40) + 16'd4, 4'd4, 64'h0, "R5 upper word zero");
        wr(route_addr(40) + 16'd4, 4'd4, 64'hFFFF_FFFF, 1'b0, "R5 upper write");
        rd(route_addr(40), 4'd8, 64'h00BC_DEF0, "R5 upper write ignored");
        rd(route_addr(41), 4'd8, 64'h0, "R5 neighbour untouched");
        wr(route_addr(32), 4'd4, 64'h0011_2233, 1'b0, "R5 first shared write");
        rd(route_addr(32), 4'd8, 64'h0011_2233, "R5 first shared slot");
        wr(route_addr(95), 4'd4, 64'h00AB_CDEF, 1'b0, "R8 last shared write");
        rd(route_addr(95), 4'd8, 64'h00AB_CDEF, "R8 last shared slot");

        // R7 private, R8 out of range
        wr(route_addr(5), 4'd4, 64'h0077_7777, 1'b0, "R7 private write");
        rd(route_addr(5), 4'd8, 64'h0, "R7 private reads zero");
        wr(route_addr(96), 4'd4, 64'h0066_6666, 1'b0, "R8 beyond range write");
        rd(route_addr(96), 4'd8, 64'h0, "R8 beyond range zero");
        rd(route_addr(32), 4'd8, 64'h0011_2233, "R8 no alias onto slot 32");
        rd(route_addr(95), 4'd8, 64'h00AB_CDEF, "R8 slot 95 intact");

        // R9 identification area
        rd(16'hFFE8, 4'd4, 64'h3B, "R9 id2 value");
        rd(16'hFFE0, 4'd4, 64'h0, "R9 other id zero");
        rd(16'h1000, 4'd4, 64'h0, "R9 unmapped zero");

        // R10 reset clears routing and enable
        wr(16'h0000, 4'd4, 64'h2, 1'b1, "R2 enable before reset");
        @(negedge clk);
        @(negedge clk);
        do_reset();
        check("R10 enable cleared", 64'(grp_enable), 64'd0);
        rd(route_addr(40), 4'd8, 64'h0, "R10 route cleared");
        rd(route_addr(95), 4'd8, 64'h0, "R10 last route cleared");

        repeat (3) @(negedge clk);
        check("R11 all responses seen", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule